// File: doc/BRIEF.md
# Three-Colour Linear CCD Drive Timing Generator

This block produces all digital drive waveforms for a three-colour linear CCD sensor from a single system clock. It drives two complementary shift clocks, a reset-gate pulse once per pixel period, a transfer-gate pulse to all three colour rows, and a two-wire colour-select code. Each line is read out in one colour, and successive lines rotate blue, green, red. Downstream capture logic receives a line-start strobe, the current colour, a pixel index, a region tag, and flags for valid and optical-black pixels.

Each line follows a fixed sequence. First comes a one-cycle line-start (load) slot. Then comes a front guard with the first shift clock held high, then the transfer pulse, then a rear guard. After that the readout runs: leading dummy outputs, optical-black pixels, two invalid pixels, the valid pixels, and three trailing invalid pixels. The pixel half-period, the transfer width and the guard width are counts of the system clock. They are written through a small register port and take effect only at the next line start. Values outside the legal range are clamped when they are loaded.

Top module: `ccd_timing_gen`

## Requirements
- R1: While reset is held, the select code is blue (both select lines high), the transfer gates are low and the first shift clock is high.
- R2: The select lines never show both low. The codes are: blue = 1,1; green = first 1, second 0; red = first 0, second 1.
- R3: The colour code (blue 0, green 1, red 2) changes only in a line-start cycle. It steps blue, green, red, blue, and the first line after reset is blue.
- R4: A line starts with one line-start cycle. Then come G cycles of front guard, X cycles of transfer pulse on all three gates, G cycles of rear guard, and N_TOT pixel periods of readout. G and X are the values loaded at that line start.
- R5: The two shift clocks are always complementary. Outside readout the first shift clock is high. During readout it is high for the first H cycles of each 2H-cycle pixel period.
- R6: The reset gate pulses high for one cycle and then stays low for the rest of a free-running 2H-cycle period. This includes the guard and transfer windows.
- R7: During readout the pixel index counts 0..N_TOT-1. The region tag codes are none 0, dummy 1, optical black 2, invalid 3, valid 4. The regions are N_DUM dummy pixels, then N_OB optical black, N_INVL invalid, N_VAL valid, and N_INVT invalid. The valid and optical-black flags follow the tag. Outside readout the index is 0 and the tag is none.
- R8: Writes go to address 0 (half period H), address 1 (transfer width X) and address 2 (guard G). A write takes effect at the next line start. A write made during a line-start cycle applies one line later.
- R9: On load, H is clamped to [HALF_MIN, HALF_MAX], X to at least XFER_MIN, and G to [GUARD_MIN, GUARD_MAX].
- R10: A write to address 3 has no effect on any timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | CW | Register write data |
| sh1_o | output | 1 | First shift clock |
| sh2_o | output | 1 | Second shift clock, complement of first |
| rgate_o | output | 1 | Reset-gate pulse |
| xfer_o | output | 3 | Transfer-gate pulses (one per colour row) |
| sel_a_o | output | 1 | First colour-select line |
| sel_b_o | output | 1 | Second colour-select line |
| line_start_o | output | 1 | Line-start strobe |
| color_o | output | 2 | Current colour code |
| pix_idx_o | output | PW | Readout pixel index |
| region_o | output | 3 | Region tag |
| valid_o | output | 1 | Valid-pixel flag |
| oblk_o | output | 1 | Optical-black flag |

## Verification
A register write can land in the same cycle as the line-start load that copies the staged values into the active set. The bench provokes this by writing a new half period exactly in a line-start cycle, after an earlier write in the line before. Its model expects the line that follows to keep the earlier value and the line after that to take the new, clamped one. The judgement rests on the shift-clock, reset-gate and pixel-index timing of both lines, compared cycle by cycle.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic [1:0] {
    COL_BLUE  = 2'd0,
    COL_GREEN = 2'd1,
    COL_RED   = 2'd2
  } color_e;

  typedef enum logic [2:0] {
    RGN_NONE  = 3'd0,
    RGN_DUMMY = 3'd1,
    RGN_OBLK  = 3'd2,
    RGN_INVAL = 3'd3,
    RGN_VALID = 3'd4
  } region_e;

  typedef enum logic [2:0] {
    PH_LOAD,
    PH_GUARD_A,
    PH_XFER,
    PH_GUARD_B,
    PH_READ
  } phase_e;

  function automatic logic [31:0] clamp_u(input logic [31:0] v,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/ccd_cfg_regs.sv
module ccd_cfg_regs
  import ccd_tg_pkg::*;
#(
  parameter int CW        = 16,
  parameter int HALF_DEF  = 12,
  parameter int HALF_MIN  = 7,
  parameter int HALF_MAX  = 25,
  parameter int XFER_DEF  = 500,
  parameter int XFER_MIN  = 150,
  parameter int GUARD_DEF = 47,
  parameter int GUARD_MIN = 45,
  parameter int GUARD_MAX = 49
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          load_i,
  output logic [CW-1:0] half_o,
  output logic [CW-1:0] xfer_o,
  output logic [CW-1:0] guard_o
);

  localparam logic [31:0] XFER_TOP = 32'((64'd1 << CW) - 64'd1);

  logic [CW-1:0] st_half_q, st_xfer_q, st_guard_q;
  logic          wr_half, wr_xfer, wr_guard;
  logic [CW-1:0] half_d, xfer_d, guard_d;

  assign wr_half  = we_i && (addr_i == 2'd0);
  assign wr_xfer  = we_i && (addr_i == 2'd1);
  assign wr_guard = we_i && (addr_i == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_half_q  <= CW'(HALF_DEF);
      st_xfer_q  <= CW'(XFER_DEF);
      st_guard_q <= CW'(GUARD_DEF);
    end else begin
      if (wr_half)  st_half_q  <= wdata_i;
      if (wr_xfer)  st_xfer_q  <= wdata_i;
      if (wr_guard) st_guard_q <= wdata_i;
    end
  end

  always_comb begin
    half_d  = CW'(clamp_u(32'(st_half_q),  32'(HALF_MIN),  32'(HALF_MAX)));
    xfer_d  = CW'(clamp_u(32'(st_xfer_q),  32'(XFER_MIN),  XFER_TOP));
    guard_d = CW'(clamp_u(32'(st_guard_q), 32'(GUARD_MIN), 32'(GUARD_MAX)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_o  <= CW'(HALF_DEF);
      xfer_o  <= CW'(XFER_DEF);
      guard_o <= CW'(GUARD_DEF);
    end else if (load_i) begin
      half_o  <= half_d;
      xfer_o  <= xfer_d;
      guard_o <= guard_d;
    end
  end

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_tg_pkg::*;
#(
  parameter int CW    = 16,
  parameter int N_TOT = 2769,
  parameter int PW    = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] half_i,
  input  logic [CW-1:0] xfer_i,
  input  logic [CW-1:0] guard_i,
  output phase_e        phase_o,
  output logic [PW-1:0] pix_o,
  output color_e        color_o,
  output logic          sh1_o,
  output logic          rgate_o
);

  localparam logic [PW-1:0] PIX_LAST = PW'(N_TOT - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   sp_q, sp_d, rp_q, rp_d, per_last;
  logic [PW-1:0] pix_q, pix_d;
  color_e        color_q, color_d;
  logic          pix_en, line_end;

  assign per_last = {half_i, 1'b0} - (CW+1)'(1);

  // free-running reset-gate period counter
  assign rp_d = (rp_q >= per_last) ? '0 : rp_q + (CW+1)'(1);

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    sp_d     = sp_q;
    pix_d    = pix_q;
    pix_en   = 1'b0;
    line_end = 1'b0;
    unique case (phase_q)
      PH_LOAD: begin
        phase_d = PH_GUARD_A;
        cnt_d   = '0;
      end
      PH_GUARD_A: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == guard_i - CW'(1)) begin
          phase_d = PH_XFER;
          cnt_d   = '0;
        end
      end
      PH_XFER: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == xfer_i - CW'(1)) begin
          phase_d = PH_GUARD_B;
          cnt_d   = '0;
        end
      end
      PH_GUARD_B: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == guard_i - CW'(1)) begin
          phase_d = PH_READ;
          cnt_d   = '0;
        end
      end
      PH_READ: begin
        sp_d = sp_q + (CW+1)'(1);
        if (sp_q == per_last) begin
          sp_d   = '0;
          pix_en = 1'b1;
          if (pix_q == PIX_LAST) begin
            pix_d    = '0;
            line_end = 1'b1;
            phase_d  = PH_LOAD;
          end else begin
            pix_d = pix_q + PW'(1);
          end
        end
      end
      default: phase_d = PH_LOAD;
    endcase
  end

  always_comb begin
    unique case (color_q)
      COL_BLUE:  color_d = COL_GREEN;
      COL_GREEN: color_d = COL_RED;
      default:   color_d = COL_BLUE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      sp_q    <= '0;
      rp_q    <= '0;
      pix_q   <= '0;
      color_q <= COL_BLUE;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sp_q    <= sp_d;
      rp_q    <= rp_d;
      if (pix_en)   pix_q   <= pix_d;
      if (line_end) color_q <= color_d;
    end
  end

  assign phase_o = phase_q;
  assign pix_o   = pix_q;
  assign color_o = color_q;
  assign sh1_o   = (phase_q != PH_READ) || (sp_q < {1'b0, half_i});
  assign rgate_o = (rp_q == '0);

endmodule

// File: rtl/ccd_region_map.sv
module ccd_region_map
  import ccd_tg_pkg::*;
#(
  parameter int N_DUM  = 16,
  parameter int N_OB   = 48,
  parameter int N_INVL = 2,
  parameter int N_VAL  = 2700,
  parameter int PW     = 12
) (
  input  logic          in_read_i,
  input  logic [PW-1:0] pix_i,
  output region_e       region_o,
  output logic          valid_o,
  output logic          oblk_o
);

  localparam int B_OB  = N_DUM;
  localparam int B_INV = B_OB + N_OB;
  localparam int B_VAL = B_INV + N_INVL;
  localparam int B_TR  = B_VAL + N_VAL;

  always_comb begin
    if (!in_read_i)                      region_o = RGN_NONE;
    else if (pix_i < PW'(B_OB))          region_o = RGN_DUMMY;
    else if (pix_i < PW'(B_INV))         region_o = RGN_OBLK;
    else if (pix_i < PW'(B_VAL))         region_o = RGN_INVAL;
    else if (pix_i < PW'(B_TR))          region_o = RGN_VALID;
    else                                 region_o = RGN_INVAL;
  end

  assign valid_o = (region_o == RGN_VALID);
  assign oblk_o  = (region_o == RGN_OBLK);

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int CW        = 16,
  parameter int N_DUM     = 16,
  parameter int N_OB      = 48,
  parameter int N_INVL    = 2,
  parameter int N_VAL     = 2700,
  parameter int N_INVT    = 3,
  parameter int HALF_DEF  = 12,
  parameter int HALF_MIN  = 7,
  parameter int HALF_MAX  = 25,
  parameter int XFER_DEF  = 500,
  parameter int XFER_MIN  = 150,
  parameter int GUARD_DEF = 47,
  parameter int GUARD_MIN = 45,
  parameter int GUARD_MAX = 49,
  localparam int N_TOT    = N_DUM + N_OB + N_INVL + N_VAL + N_INVT,
  localparam int PW       = $clog2(N_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [CW-1:0] cfg_wdata_i,
  output logic          sh1_o,
  output logic          sh2_o,
  output logic          rgate_o,
  output logic [2:0]    xfer_o,
  output logic          sel_a_o,
  output logic          sel_b_o,
  output logic          line_start_o,
  output logic [1:0]    color_o,
  output logic [PW-1:0] pix_idx_o,
  output logic [2:0]    region_o,
  output logic          valid_o,
  output logic          oblk_o
);

  logic          rs1_q, rs2_q, rst_sync_n;
  logic [CW-1:0] half, xfer, guard;
  phase_e        phase;
  color_e        color;
  logic [PW-1:0] pix;
  region_e       region;
  logic          sh1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  ccd_cfg_regs #(
    .CW(CW), .HALF_DEF(HALF_DEF), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX),
    .XFER_DEF(XFER_DEF), .XFER_MIN(XFER_MIN), .GUARD_DEF(GUARD_DEF),
    .GUARD_MIN(GUARD_MIN), .GUARD_MAX(GUARD_MAX)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .load_i(phase == PH_LOAD),
    .half_o(half), .xfer_o(xfer), .guard_o(guard)
  );

  ccd_line_seq #(.CW(CW), .N_TOT(N_TOT), .PW(PW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .half_i(half), .xfer_i(xfer),
    .guard_i(guard), .phase_o(phase), .pix_o(pix), .color_o(color),
    .sh1_o(sh1), .rgate_o(rgate_o)
  );

  ccd_region_map #(
    .N_DUM(N_DUM), .N_OB(N_OB), .N_INVL(N_INVL), .N_VAL(N_VAL), .PW(PW)
  ) u_rgn (
    .in_read_i(phase == PH_READ), .pix_i(pix),
    .region_o(region), .valid_o(valid_o), .oblk_o(oblk_o)
  );

  assign sh1_o        = sh1;
  assign sh2_o        = !sh1;
  assign xfer_o       = {3{phase == PH_XFER}};
  assign sel_a_o      = (color != COL_RED);
  assign sel_b_o      = (color != COL_GREEN);
  assign line_start_o = (phase == PH_LOAD);
  assign color_o      = color;
  assign pix_idx_o    = pix;
  assign region_o     = region;

endmodule

// File: rtl/ccd_timing_gen_chk.sv
module ccd_timing_gen_chk (
  input logic       clk_i,
  input logic       rst_n,
  input logic       sh1,
  input logic       sh2,
  input logic       rgate,
  input logic [2:0] xfer,
  input logic       sel_a,
  input logic       sel_b,
  input logic       line_start,
  input logic [1:0] color,
  input logic       valid,
  input logic       oblk
);

  AST_SEL_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    sel_a || sel_b); // R2

  AST_SHIFT_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_n)
    sh1 != sh2); // R5

  AST_XFER_HOLDS_SH1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (xfer != 3'b000) |-> (sh1 && !valid && !oblk)); // R5

  AST_XFER_GATES_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_n)
    (xfer == 3'b000) || (xfer == 3'b111)); // R4

  AST_COLOR_AT_START: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(color) |-> line_start); // R3

  AST_COLOR_ROTATION: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(color) |-> (($past(color) == 2'd2) ? (color == 2'd0)
                                                : (color == $past(color) + 2'd1))); // R3

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    line_start |=> !line_start); // R4

  AST_RGATE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    rgate |=> !rgate); // R6

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(valid && oblk)); // R7

endmodule

bind ccd_timing_gen ccd_timing_gen_chk u_chk (
  .clk_i(clk_i), .rst_n(rst_sync_n), .sh1(sh1_o), .sh2(sh2_o), .rgate(rgate_o),
  .xfer(xfer_o), .sel_a(sel_a_o), .sel_b(sel_b_o), .line_start(line_start_o),
  .color(color_o), .valid(valid_o), .oblk(oblk_o)
);

// File: tb/ccd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module ccd_timing_gen_tb_top;
  localparam int CW = 16, ND = 4, NO = 6, NIL = 2, NV = 20, NIT = 3;
  localparam int NT = ND + NO + NIL + NV + NIT;
  localparam int PWB = $clog2(NT);
  localparam int LINES = 6, LIMIT = 50000;

  logic clk = 1'b0;
  logic rst_n;
  logic we;
  logic [1:0] addr;
  logic [CW-1:0] wdata;
  logic sh1, sh2, rg, sa, sb, ls, vld, ob;
  logic [2:0] xf, rgn;
  logic [1:0] col;
  logic [PWB-1:0] pix;

  always #10 clk = ~clk;

  ccd_timing_gen #(.CW(CW), .N_DUM(ND), .N_OB(NO), .N_INVL(NIL), .N_VAL(NV),
                   .N_INVT(NIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .sh1_o(sh1), .sh2_o(sh2), .rgate_o(rg), .xfer_o(xf),
    .sel_a_o(sa), .sel_b_o(sb), .line_start_o(ls), .color_o(col),
    .pix_idx_o(pix), .region_o(rgn), .valid_o(vld), .oblk_o(ob)
  );

  int vecs = 0, bad = 0;
  int t, line_n, lh, lx, lg, rs, lenv, rp;
  int st_h, st_x, st_g;

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s line %0d t %0d: actual %0d expected %0d",
               req, what, line_n, t, act, exp);
    end
  endtask

  task automatic compare();
    int c, p, k, e_rgn, e_phi;
    c = line_n % 3;
    p = 2 * lh;
    chk("R2", "sel_a", int'(sa), (c != 2) ? 1 : 0);
    chk("R2", "sel_b", int'(sb), (c != 1) ? 1 : 0);
    chk("R3", "color", int'(col), c);
    chk("R4", "line_start", int'(ls), (t == 0) ? 1 : 0);
    chk("R4", "xfer", int'(xf), (t > 0 && t >= lg + 1 && t <= lg + lx) ? 7 : 0);
    e_phi = (t == 0 || t < rs) ? 1 : ((((t - rs) % p) < lh) ? 1 : 0);
    chk("R5", "sh1", int'(sh1), e_phi);
    chk("R5", "sh2", int'(sh2), 1 - e_phi);
    chk("R6", "rgate", int'(rg), (rp == 0) ? 1 : 0);
    k = (t > 0 && t >= rs) ? (t - rs) / p : 0;
    if (t == 0 || t < rs) e_rgn = 0;
    else if (k < ND) e_rgn = 1;
    else if (k < ND + NO) e_rgn = 2;
    else if (k < ND + NO + NIL) e_rgn = 3;
    else if (k < ND + NO + NIL + NV) e_rgn = 4;
    else e_rgn = 3;
    chk("R7", "pix_idx", int'(pix), k);
    chk("R7", "region", int'(rgn), e_rgn);
    chk("R7", "valid", int'(vld), (e_rgn == 4) ? 1 : 0);
    chk("R7", "oblk", int'(ob), (e_rgn == 2) ? 1 : 0);
  endtask

  task automatic advance();
    rp = (rp >= 2 * lh - 1) ? 0 : rp + 1;
    if (t == 0) begin
      lh = lim(st_h, 7, 25);
      lx = lim(st_x, 150, 65535);
      lg = lim(st_g, 45, 49);
      rs = 2 * lg + lx + 1;
      lenv = rs + NT * 2 * lh;
    end
    if (we) begin
      if (addr == 2'd0) st_h = int'(wdata);
      if (addr == 2'd1) st_x = int'(wdata);
      if (addr == 2'd2) st_g = int'(wdata);
    end
    t++;
    if (t == lenv) begin
      t = 0;
      line_n++;
    end
  endtask

  task automatic put(int a, int d);
    we = 1'b1;
    addr = 2'(a);
    wdata = CW'(d);
  endtask

  initial begin
    int cyc;
    rst_n = 1'b0;
    we = 1'b0;
    addr = '0;
    wdata = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "sel_a", int'(sa), 1);
    chk("R1", "sel_b", int'(sb), 1);
    chk("R1", "xfer", int'(xf), 0);
    chk("R1", "sh1", int'(sh1), 1);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    t = 0; line_n = 0; rp = 0;
    st_h = 12; st_x = 500; st_g = 47;
    lh = 12; lx = 500; lg = 47; rs = 1; lenv = 1;
    cyc = 0;
    while (line_n < LINES && cyc < LIMIT) begin
      @(negedge clk);
      compare();
      we = 1'b0;
      if (line_n == 0 && t == 200) put(0, 7);        // R8 half period
      if (line_n == 0 && t == 201) put(1, 100);      // R9 transfer clamps up
      if (line_n == 0 && t == 202) put(2, 60);       // R9 guard clamps down
      if (line_n == 0 && t == 203) put(3, 9);        // R10 ignored address
      if (line_n == 1 && t == 0)   put(0, 40);       // R8 write in load cycle, R9 clamp
      if (line_n == 2 && t == 10)  put(0, 2);        // R9 half clamps up
      if (line_n == 2 && t == 11)  put(2, 10);       // R9 guard clamps up
      if (line_n == 3 && t == 5)   put(1, 160);      // R8 transfer width
      if (line_n == 4 && t == 7)   put(3, 1);        // R10 ignored address
      advance();
      cyc++;
    end
    if (line_n < LINES) begin
      bad++;
      $display("FAIL R4 watchdog: actual %0d lines expected %0d", line_n, LINES);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule